// File: doc/BRIEF.md
# Seek Time Watchdog Counter

This block watches a disk head positioner for stalls. Whenever the positioner reports that a seek is in progress, a counter advances on a slow, prescaled enable tick. Outside a seek the counter is forced to zero and held there. Every seek therefore starts its count from zero. The same maximum duration applies to every seek, whatever distance the heads travel.

If the counter would step past its all-ones value while the seek is still running, the block raises a seek-time error. In the same cycle it issues a one-cycle emergency-unload request. The error stays set until reset or a restore operation. A restore operation clears the counter and the error, and it disables the check for as long as it lasts.

Top module: `seek_watchdog`

## Requirements
- R1: After a synchronous reset, `count_o` is zero and `seek_err_o` and `unload_req_o` are low.
- R2: While `busy_i` is high and `restore_i` is low, `count_o` increases by one on each clock edge where `tick_i` is high. It does not change on edges where `tick_i` is low.
- R3: On any clock edge where `busy_i` is low and `restore_i` is low, `count_o` becomes zero and stays at zero while `busy_i` remains low.
- R4: A tick while busy, with `count_o` at all ones (2^CNT_W − 1), sets `seek_err_o` and leaves `count_o` at all ones. The error first appears 2^CNT_W ticks after busy rises.
- R5: If `busy_i` falls before 2^CNT_W ticks have been counted, `seek_err_o` stays low and `count_o` returns to zero.
- R6: `unload_req_o` is high for exactly the one cycle in which `seek_err_o` changes from low to high, and at no other time.
- R7: Once set, `seek_err_o` stays high while `busy_i` falls and while further ticks arrive, until reset or `restore_i`.
- R8: On any clock edge where `restore_i` is high, `count_o` and `seek_err_o` become zero. This takes priority over counting and over setting the error, even when the counter is at all ones and a busy tick arrives.
- R9: Ticks that arrive while `busy_i` is low have no effect on `count_o` or `seek_err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Prescaled count enable, one cycle per tick |
| busy_i | input | 1 | Seek in progress |
| restore_i | input | 1 | Restore operation active; clears the counter and the error and suspends the check |
| count_o | output | CNT_W | Elapsed ticks in the current seek |
| seek_err_o | output | 1 | Latched seek-time error |
| unload_req_o | output | 1 | One-cycle emergency-unload request |

## Verification
The bench builds the block with CNT_W = 4, so the limit is 16 ticks. Overflow, the hold at all ones after the error, and an error while the counter sits at its limit can then all be reached within a few dozen cycles. Ticks are driven both densely (every cycle) and sparsely (every third cycle), so that clock edges without a tick are seen during a seek. A behavioural reference model is compared with all three outputs every cycle. The runs include seeks that end one tick short of the limit and a restore that lands on the same edge as an overflowing tick.

// File: rtl/sw_pkg.sv
package sw_pkg;

    // Per-edge action chosen for the counter, in priority order
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,   // restore: clear everything
        MODE_IDLE  = 2'd1,   // not busy: force zero
        MODE_HOLD  = 2'd2,   // busy, no tick
        MODE_STEP  = 2'd3    // busy and tick
    } sw_mode_e;

    typedef struct packed {
        sw_mode_e mode;
        logic     overflow;  // step requested while counter at all ones
    } sw_evt_t;

    function automatic sw_mode_e sw_pick_mode(input logic restore,
                                               input logic busy,
                                               input logic tick);
        if (restore)   return MODE_CLEAR;
        else if (!busy) return MODE_IDLE;
        else if (tick)  return MODE_STEP;
        else            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/sw_mode_dec.sv
module sw_mode_dec
    import sw_pkg::*;
(
    input  logic     restore_i,
    input  logic     busy_i,
    input  logic     tick_i,
    output sw_mode_e mode_o
);

    always_comb begin
        mode_o = sw_pick_mode(restore_i, busy_i, tick_i);
    end

endmodule

// File: rtl/sw_counter.sv
module sw_counter
    import sw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  sw_mode_e         mode_i,
    output logic [CNT_W-1:0] count_o,
    output sw_evt_t          evt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic             at_max;

    assign at_max = (cnt_q == CNT_MAX);

    always_comb begin
        evt_o.mode     = mode_i;
        evt_o.overflow = (mode_i == MODE_STEP) && at_max;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (mode_i)
                MODE_CLEAR, MODE_IDLE: cnt_q <= '0;
                MODE_HOLD:             cnt_q <= cnt_q;
                MODE_STEP:             if (!at_max) cnt_q <= cnt_q + 1'b1;
                default:               cnt_q <= cnt_q;
            endcase
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/sw_flag.sv
module sw_flag
    import sw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sw_evt_t evt_i,
    output logic    err_o,
    output logic    pulse_o
);

    logic err_q;
    logic pulse_q;
    logic set_now;

    assign set_now = evt_i.overflow && (evt_i.mode != MODE_CLEAR);

    always_ff @(posedge clk) begin
        if (rst || evt_i.mode == MODE_CLEAR) begin
            err_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= set_now && !err_q;
            if (set_now) err_q <= 1'b1;
        end
    end

    assign err_o   = err_q;
    assign pulse_o = pulse_q;

endmodule

// File: rtl/seek_watchdog.sv
module seek_watchdog
    import sw_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             busy_i,
    input  logic             restore_i,
    output logic [CNT_W-1:0] count_o,
    output logic             seek_err_o,
    output logic             unload_req_o
);

    sw_mode_e mode;
    sw_evt_t  evt;

    sw_mode_dec u_dec (
        .restore_i (restore_i),
        .busy_i    (busy_i),
        .tick_i    (tick_i),
        .mode_o    (mode)
    );

    sw_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode),
        .count_o (count_o),
        .evt_o   (evt)
    );

    sw_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt),
        .err_o   (seek_err_o),
        .pulse_o (unload_req_o)
    );

endmodule

// File: rtl/sw_chk.sv
module sw_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_i,
    input logic             busy_i,
    input logic             restore_i,
    input logic [CNT_W-1:0] count_o,
    input logic             seek_err_o,
    input logic             unload_req_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R3
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_i && !restore_i) |=> (count_o == '0));

    // R8
    restore_clear_chk: assert property (@(posedge clk) disable iff (rst)
        restore_i |=> (count_o == '0 && !seek_err_o));

    // R2
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !restore_i && !tick_i) |=> $stable(count_o));

    // R4
    overflow_err_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && tick_i && !restore_i && count_o == CNT_MAX) |=> seek_err_o);

    // R6
    unload_single_chk: assert property (@(posedge clk) disable iff (rst)
        unload_req_o |=> !unload_req_o);

    // R6
    unload_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(seek_err_o) |-> unload_req_o);

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (seek_err_o && !restore_i) |=> seek_err_o);

endmodule

bind seek_watchdog sw_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_i),
    .busy_i       (busy_i),
    .restore_i    (restore_i),
    .count_o      (count_o),
    .seek_err_o   (seek_err_o),
    .unload_req_o (unload_req_o)
);

// File: tb/seek_watchdog_tb.sv
module seek_watchdog_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int LIMIT      = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick_i = 1'b0;
    logic             busy_i = 1'b0;
    logic             restore_i = 1'b0;
    logic [CNT_W-1:0] count_o;
    logic             seek_err_o;
    logic             unload_req_o;

    int    checks = 0;
    int    errors = 0;
    int    cyc    = 0;
    string phase  = "R1";

    // reference model state
    int m_cnt = 0;
    bit m_err = 0;
    bit m_unl = 0;

    seek_watchdog #(.CNT_W(CNT_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .busy_i       (busy_i),
        .restore_i    (restore_i),
        .count_o      (count_o),
        .seek_err_o   (seek_err_o),
        .unload_req_o (unload_req_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference
    always @(posedge clk) begin
        cyc++;
        if (rst || restore_i) begin
            m_cnt = 0; m_err = 0; m_unl = 0;
        end else if (!busy_i) begin
            m_cnt = 0; m_unl = 0;
        end else if (tick_i) begin
            if (m_cnt == LIMIT) begin
                m_unl = !m_err;
                m_err = 1;
            end else begin
                m_cnt = m_cnt + 1;
                m_unl = 0;
            end
        end else begin
            m_unl = 0;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(phase, int'(count_o), m_cnt, "count (model)");
            check(phase, int'(seek_err_o), int'(m_err), "error (model)");
            check(phase, int'(unload_req_o), int'(m_unl), "unload (model)");
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // drive n cycles; tick every 'period' cycles (0 = never)
    task automatic run(input int n, input bit b, input bit r, input int period, input string tag);
        phase = tag;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            busy_i    = b;
            restore_i = r;
            tick_i    = (period > 0) && ((i % period) == period - 1);
        end
    endtask

    task automatic settle;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", int'(count_o), 0, "count after reset");
        check("R1", int'(seek_err_o), 0, "error after reset");
        check("R1", int'(unload_req_o), 0, "unload after reset");

        // R9: ticks while idle do nothing
        run(6, 1'b0, 1'b0, 1, "R9");
        settle();
        check("R9", int'(count_o), 0, "count after idle ticks");
        check("R9", int'(seek_err_o), 0, "error after idle ticks");

        // R2: dense ticks
        run(5, 1'b1, 1'b0, 1, "R2");
        settle();
        check("R2", int'(count_o), 5, "count after 5 ticks");
        // R2: busy without ticks holds
        run(4, 1'b1, 1'b0, 0, "R2");
        settle();
        check("R2", int'(count_o), 5, "count held without ticks");
        // R3: busy drop zeroes
        run(3, 1'b0, 1'b0, 0, "R3");
        settle();
        check("R3", int'(count_o), 0, "count after busy low");

        // R5: sparse ticks, end one tick short of the limit
        run(3 * LIMIT, 1'b1, 1'b0, 3, "R5");
        settle();
        check("R5", int'(count_o), LIMIT, "count at limit, no error");
        check("R5", int'(seek_err_o), 0, "no error before limit");
        run(2, 1'b0, 1'b0, 1, "R5");
        settle();
        check("R5", int'(count_o), 0, "count back to zero");
        check("R5", int'(seek_err_o), 0, "error still low");

        // R4 / R6: overflow on the 16th tick
        run(LIMIT + 1, 1'b1, 1'b0, 1, "R4");
        settle();
        check("R4", int'(seek_err_o), 1, "error on overflow tick");
        check("R4", int'(count_o), LIMIT, "count held at all ones");
        check("R6", int'(unload_req_o), 1, "unload pulse with error");
        run(1, 1'b1, 1'b0, 1, "R6");
        settle();
        check("R6", int'(unload_req_o), 0, "unload pulse ends");

        // R7: error stays through busy drop and more seeks
        run(4, 1'b0, 1'b0, 1, "R7");
        run(5, 1'b1, 1'b0, 1, "R7");
        settle();
        check("R7", int'(seek_err_o), 1, "error latched");
        check("R7", int'(unload_req_o), 0, "no second unload");

        // R8: restore clears counter and error
        run(2, 1'b1, 1'b1, 1, "R8");
        settle();
        check("R8", int'(seek_err_o), 0, "error cleared by restore");
        check("R8", int'(count_o), 0, "count cleared by restore");

        // R8: restore on the same edge as an overflowing tick
        run(LIMIT, 1'b1, 1'b0, 1, "R8");
        settle();
        check("R8", int'(count_o), LIMIT, "count at limit before restore");
        run(1, 1'b1, 1'b1, 1, "R8");
        settle();
        check("R8", int'(seek_err_o), 0, "restore beats overflow");
        check("R8", int'(unload_req_o), 0, "no unload under restore");
        check("R8", int'(count_o), 0, "count zero under restore");

        // R8: long restore with busy ticks never counts
        run(3 * LIMIT, 1'b1, 1'b1, 1, "R8");
        settle();
        check("R8", int'(seek_err_o), 0, "no error during restore");

        // R1: reset clears a latched error
        run(LIMIT + 1, 1'b1, 1'b0, 1, "R4");
        settle();
        check("R4", int'(seek_err_o), 1, "error set again");
        @(negedge clk);
        phase = "R1";
        rst = 1'b1;
        busy_i = 1'b0;
        tick_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", int'(seek_err_o), 0, "error cleared by reset");
        check("R1", int'(count_o), 0, "count cleared by reset");

        run(4, 1'b0, 1'b0, 0, "R3");
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule